// File: doc/BRIEF.md
# Age-Ordered Issue Queue

This block is the central waiting room of an out-of-order core's scheduler. Decoded and renamed instructions enter it with two source physical-register tags, a ready flag for each source, a function-unit class, an opaque payload (for example a reorder-buffer index) and the cycle number at which they were dispatched. Entries hold no operand values, because operands are read from the register file after issue. An entry waits until both sources are ready. A source becomes ready when a physical tag broadcast on the result bus matches it.

Each cycle the queue selects at most one instruction per function-unit class: integer/logic/compare, multiply, and branch/jump. Among the ready candidates of a class, the winner is the one with the smallest dispatch stamp. A busy input per unit holds back issue to that unit. This covers the non-pipelined multiplier, which stays busy for three cycles. A flush input carries the stamp of a mispredicted branch and removes every entry dispatched after it.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue is empty, `disp_ready` is 1 and all three `iss_valid` bits are 0.
- R2: An entry with an unready source stays unissued until a broadcast with that source's tag appears. It may issue in the same cycle as that broadcast, provided the other source is also ready.
- R3: When several eligible entries share a class, the entry issued is the one with the smallest dispatch stamp, regardless of which slot it occupies.
- R4: While `fu_busy[k]` is 1, `iss_valid[k]` is 0. Issue to the other classes is unaffected. The class encoding is 0 for integer, 1 for multiply and 2 for branch (bit k of `fu_busy` and `iss_valid`, field k of the issue buses).
- R5: The queue holds 24 entries. `disp_ready` is 0 exactly when all 24 are occupied, and a dispatch offered while it is 0 is dropped.
- R6: An issued entry is freed at the end of its issue cycle. A dispatched entry can first issue in the cycle after it is written.
- R7: A broadcast in the same cycle as a dispatch marks the matching source of the new entry ready.
- R8: When `flush_valid` is 1, every entry whose stamp is greater than `flush_stamp` is removed at the end of the cycle and is not issued in that cycle. A dispatch in that cycle is dropped, and older entries are kept.
- R9: All three classes can issue in the same cycle, each with its own payload and stamp on its field of `iss_payload` and `iss_stamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free entry exists |
| disp_fu | input | 2 | Function-unit class of the dispatched instruction |
| disp_tag_a | input | TAG_W | First source physical tag |
| disp_rdy_a | input | 1 | First source already ready |
| disp_tag_b | input | TAG_W | Second source physical tag |
| disp_rdy_b | input | 1 | Second source already ready |
| disp_stamp | input | STAMP_W | Dispatch cycle number |
| disp_payload | input | PAY_W | Opaque instruction payload |
| bcast_valid | input | 1 | Result tag broadcast valid |
| bcast_tag | input | TAG_W | Broadcast physical tag |
| fu_busy | input | 3 | Per-class unit busy |
| iss_valid | output | 3 | Per-class issue strobe |
| iss_payload | output | 3*PAY_W | Payload of each issued entry, field k for class k |
| iss_stamp | output | 3*STAMP_W | Stamp of each issued entry, field k for class k |
| flush_valid | input | 1 | Squash younger entries |
| flush_stamp | input | STAMP_W | Stamp of the mispredicted branch |

## Verification
The hardest situation to reach from the ports is the one where age order and slot order disagree. Here a young instruction sits in a low-numbered slot freed by an earlier issue, while an older one of the same class waits in a higher slot. A long random run reaches it by mixing issue, flush and refill so that slots are reused out of order. Random tags are drawn from a small range so that broadcasts hit waiting sources often. Directed sequences fill the queue to its limit, wake all 24 entries with one broadcast, and flush in the same cycle as a wake and a dispatch.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int NFU = 3;
  typedef enum logic [1:0] {
    FU_INT = 2'd0,
    FU_MUL = 2'd1,
    FU_BR  = 2'd2
  } fu_class_e;
endpackage

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
  parameter int N  = 24,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/iq_age_pick.sv
module iq_age_pick #(
  parameter int N  = 24,
  parameter int SW = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][SW-1:0] stamp,
  output logic                 found,
  output logic [IW-1:0]        idx
);
  function automatic logic is_older(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return a < b;
  endfunction

  logic [SW-1:0] best;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || is_older(stamp[i], best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = stamp[i];
      end
    end
  end
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH   = 24,
  parameter int TAG_W   = 6,
  parameter int PAY_W   = 8,
  parameter int STAMP_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic [1:0]               disp_fu,
  input  logic [TAG_W-1:0]         disp_tag_a,
  input  logic                     disp_rdy_a,
  input  logic [TAG_W-1:0]         disp_tag_b,
  input  logic                     disp_rdy_b,
  input  logic [STAMP_W-1:0]       disp_stamp,
  input  logic [PAY_W-1:0]         disp_payload,
  input  logic                     bcast_valid,
  input  logic [TAG_W-1:0]         bcast_tag,
  input  logic [NFU-1:0]           fu_busy,
  output logic [NFU-1:0]           iss_valid,
  output logic [NFU*PAY_W-1:0]     iss_payload,
  output logic [NFU*STAMP_W-1:0]   iss_stamp,
  input  logic                     flush_valid,
  input  logic [STAMP_W-1:0]       flush_stamp
);
  localparam int IDX_W = $clog2(DEPTH);

  function automatic logic woken(input logic rdy, input logic [TAG_W-1:0] tag,
                                 input logic bv, input logic [TAG_W-1:0] btag);
    return rdy || (bv && (tag == btag));
  endfunction

  function automatic logic younger(input logic [STAMP_W-1:0] s, input logic [STAMP_W-1:0] ref_s);
    return s > ref_s;
  endfunction

  // entry storage
  logic [DEPTH-1:0]              valid_q, ra_q, rb_q;
  logic [DEPTH-1:0][1:0]         fu_q;
  logic [DEPTH-1:0][TAG_W-1:0]   ta_q, tb_q;
  logic [DEPTH-1:0][STAMP_W-1:0] stamp_q;
  logic [DEPTH-1:0][PAY_W-1:0]   pay_q;

  // named internal events
  logic [DEPTH-1:0]            wake_a, wake_b, squash, elig, issued;
  logic [NFU-1:0][DEPTH-1:0]   cand;
  logic [NFU-1:0]              pick_found;
  logic [NFU-1:0][IDX_W-1:0]   pick_idx;
  logic                        free_found, disp_fire;
  logic [IDX_W-1:0]            free_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wake_a[i] = woken(ra_q[i], ta_q[i], bcast_valid, bcast_tag);
      wake_b[i] = woken(rb_q[i], tb_q[i], bcast_valid, bcast_tag);
      squash[i] = flush_valid && younger(stamp_q[i], flush_stamp);
      elig[i]   = valid_q[i] && wake_a[i] && wake_b[i] && !squash[i];
      for (int k = 0; k < NFU; k++)
        cand[k][i] = elig[i] && (fu_q[i] == 2'(k));
    end
  end

  iq_free_pick #(.N(DEPTH), .IW(IDX_W)) u_free (
    .free_vec (~valid_q),
    .found    (free_found),
    .idx      (free_idx)
  );

  for (genvar k = 0; k < NFU; k++) begin : g_fu
    iq_age_pick #(.N(DEPTH), .SW(STAMP_W), .IW(IDX_W)) u_pick (
      .cand  (cand[k]),
      .stamp (stamp_q),
      .found (pick_found[k]),
      .idx   (pick_idx[k])
    );
    assign iss_valid[k] = pick_found[k] && !fu_busy[k];
    assign iss_payload[k*PAY_W +: PAY_W]     = pay_q[pick_idx[k]];
    assign iss_stamp[k*STAMP_W +: STAMP_W]   = stamp_q[pick_idx[k]];
  end

  always_comb begin
    issued = '0;
    for (int k = 0; k < NFU; k++)
      if (iss_valid[k]) issued[pick_idx[k]] = 1'b1;
  end

  assign disp_ready = free_found;
  assign disp_fire  = disp_valid && free_found && !flush_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
      fu_q    <= '0;
      ta_q    <= '0;
      tb_q    <= '0;
      stamp_q <= '0;
      pay_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (issued[i] || squash[i]) begin
          valid_q[i] <= 1'b0;
        end else if (valid_q[i]) begin
          ra_q[i] <= wake_a[i];
          rb_q[i] <= wake_b[i];
        end
      end
      if (disp_fire) begin
        valid_q[free_idx] <= 1'b1;
        fu_q[free_idx]    <= disp_fu;
        ta_q[free_idx]    <= disp_tag_a;
        tb_q[free_idx]    <= disp_tag_b;
        ra_q[free_idx]    <= woken(disp_rdy_a, disp_tag_a, bcast_valid, bcast_tag);
        rb_q[free_idx]    <= woken(disp_rdy_b, disp_tag_b, bcast_valid, bcast_tag);
        stamp_q[free_idx] <= disp_stamp;
        pay_q[free_idx]   <= disp_payload;
      end
    end
  end

  // ---------------- assertions ----------------
  p_disp_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> valid_q[$past(free_idx)] && (stamp_q[$past(free_idx)] == $past(disp_stamp)));

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk
    p_freed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      issued[i] |=> !valid_q[i]);
    p_flush_gone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && valid_q[i] && younger(stamp_q[i], flush_stamp)) |=> !valid_q[i]);
    p_wait_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q[i] && !ra_q[i] && !(bcast_valid && bcast_tag == ta_q[i])) |-> !issued[i]);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NFU; k++)
        for (int i = 0; i < DEPTH; i++)
          p_oldest_r3: assert (!(iss_valid[k] && cand[k][i] &&
                                 stamp_q[i] < stamp_q[pick_idx[k]]))
            else $error("younger entry issued ahead of older one");
    end
  end
endmodule

// File: tb/age_issue_queue_bench.sv
`timescale 1ns/1ps
module age_issue_queue_bench;
  localparam int DEPTH = 24, TAG_W = 6, PAY_W = 8, SW = 32, NFU = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 0, disp_rdy_a = 0, disp_rdy_b = 0;
  logic disp_ready;
  logic [1:0] disp_fu = 0;
  logic [TAG_W-1:0] disp_tag_a = 0, disp_tag_b = 0, bcast_tag = 0;
  logic [SW-1:0] disp_stamp = 0, flush_stamp = 0;
  logic [PAY_W-1:0] disp_payload = 0;
  logic bcast_valid = 0, flush_valid = 0;
  logic [NFU-1:0] fu_busy = 0, iss_valid;
  logic [NFU*PAY_W-1:0] iss_payload;
  logic [NFU*SW-1:0] iss_stamp;

  always #2.5 clk = ~clk;

  age_issue_queue u_age_issue_queue (.*);

  int vectors = 0, miscompares = 0;
  string req = "R1";
  int unsigned cyc = 1;

  // reference model
  logic          m_v [DEPTH];
  logic          m_ra[DEPTH], m_rb[DEPTH];
  logic [TAG_W-1:0] m_ta[DEPTH], m_tb[DEPTH];
  logic [1:0]    m_fu[DEPTH];
  logic [SW-1:0] m_st[DEPTH];
  logic [PAY_W-1:0] m_pay[DEPTH];

  function automatic logic m_woke(logic r, logic [TAG_W-1:0] t);
    return r | (bcast_valid & (t == bcast_tag));
  endfunction

  function automatic logic m_elig(int i);
    return m_v[i] && m_woke(m_ra[i], m_ta[i]) && m_woke(m_rb[i], m_tb[i]) &&
           !(flush_valid && m_st[i] > flush_stamp);
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) if (m_v[i]) c++;
    return c;
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    disp_valid = 0; bcast_valid = 0; flush_valid = 0; fu_busy = '0;
  endtask

  // inputs already driven; check then advance one clock
  task automatic step();
    int win[NFU];
    int cnt;
    #1;
    cnt = m_count();
    chk("disp_ready", disp_ready, cnt < DEPTH);
    for (int k = 0; k < NFU; k++) begin
      win[k] = -1;
      for (int i = 0; i < DEPTH; i++)
        if (m_elig(i) && m_fu[i] == 2'(k) && (win[k] < 0 || m_st[i] < m_st[win[k]]))
          win[k] = i;
      if (fu_busy[k]) win[k] = -1;
      chk($sformatf("iss_valid[%0d]", k), iss_valid[k], win[k] >= 0);
      if (win[k] >= 0 && iss_valid[k]) begin
        chk("iss_payload", iss_payload[k*PAY_W +: PAY_W], m_pay[win[k]]);
        chk("iss_stamp", iss_stamp[k*SW +: SW], m_st[win[k]]);
      end
    end
    @(posedge clk);
    for (int k = 0; k < NFU; k++) if (win[k] >= 0) m_v[win[k]] = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && flush_valid && m_st[i] > flush_stamp) m_v[i] = 0;
      if (m_v[i]) begin
        m_ra[i] = m_woke(m_ra[i], m_ta[i]);
        m_rb[i] = m_woke(m_rb[i], m_tb[i]);
      end
    end
    if (disp_valid && cnt < DEPTH && !flush_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!m_v[i]) begin
          m_v[i] = 1; m_fu[i] = disp_fu; m_ta[i] = disp_tag_a; m_tb[i] = disp_tag_b;
          m_ra[i] = m_woke(disp_rdy_a, disp_tag_a); m_rb[i] = m_woke(disp_rdy_b, disp_tag_b);
          m_st[i] = disp_stamp; m_pay[i] = disp_payload;
          break;
        end
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic set_disp(logic [1:0] fu, logic [TAG_W-1:0] ta, logic ra,
                          logic [TAG_W-1:0] tb, logic rb);
    disp_valid = 1; disp_fu = fu; disp_tag_a = ta; disp_rdy_a = ra;
    disp_tag_b = tb; disp_rdy_b = rb; disp_stamp = cyc; disp_payload = PAY_W'($urandom);
  endtask

  initial begin
    #(5.0 * 200000);
    miscompares++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [SW-1:0] s2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    req = "R1";
    #1;
    chk("disp_ready after reset", disp_ready, 1);
    chk("iss_valid after reset", iss_valid, 0);
    rst_n = 1;
    @(negedge clk);
    idle_inputs(); step();

    // R7: broadcast during dispatch readies the new entry
    req = "R7";
    set_disp(2'd0, 6'd5, 0, 6'd0, 1); bcast_valid = 1; bcast_tag = 6'd5; step();
    idle_inputs(); step();

    // R2: waits for tag, issues in the broadcast cycle
    req = "R2";
    set_disp(2'd1, 6'd9, 0, 6'd1, 1); step();
    idle_inputs(); step(); step();
    bcast_valid = 1; bcast_tag = 6'd9; step();
    idle_inputs(); step();

    // R3: oldest first while the unit was held busy
    req = "R3";
    for (int n = 0; n < 4; n++) begin set_disp(2'd0, 0, 1, 0, 1); fu_busy = 3'b001; step(); end
    idle_inputs(); for (int n = 0; n < 5; n++) step();

    // R4: busy multiply does not block integer
    req = "R4";
    set_disp(2'd1, 0, 1, 0, 1); step();
    set_disp(2'd0, 0, 1, 0, 1); fu_busy = 3'b010; step();
    idle_inputs(); fu_busy = 3'b010; step(); step();
    idle_inputs(); step(); step();

    // R6: dispatch then issue next cycle
    req = "R6";
    set_disp(2'd2, 0, 1, 0, 1); step();
    idle_inputs(); step(); step();

    // R5: fill to capacity, drop extra dispatch
    req = "R5";
    for (int n = 0; n < DEPTH; n++) begin set_disp(2'(n % 3), 6'd63, 0, 6'd2, 1); step(); end
    set_disp(2'd0, 0, 1, 0, 1); step();
    set_disp(2'd1, 0, 1, 0, 1); step();
    // R9: one broadcast wakes all; three classes issue together
    req = "R9";
    idle_inputs(); bcast_valid = 1; bcast_tag = 6'd63; step();
    idle_inputs(); for (int n = 0; n < 10; n++) step();

    // R8: flush younger entries, same cycle as a wake and a dispatch
    req = "R8";
    s2 = '0;
    for (int n = 0; n < 6; n++) begin
      set_disp(2'(n % 3), 6'd40, 0, 0, 1);
      if (n == 2) s2 = cyc;
      step();
    end
    set_disp(2'd0, 0, 1, 0, 1); flush_valid = 1; flush_stamp = s2;
    bcast_valid = 1; bcast_tag = 6'd40; step();
    idle_inputs(); bcast_valid = 1; bcast_tag = 6'd40; step();
    idle_inputs(); for (int n = 0; n < 4; n++) step();

    // R3: random traffic with slot reuse
    req = "R3";
    for (int n = 0; n < 4000; n++) begin
      idle_inputs();
      if ($urandom % 10 < 6)
        set_disp(2'($urandom % 3), 6'($urandom % 8), 1'($urandom % 2),
                 6'($urandom % 8), 1'($urandom % 2));
      if ($urandom % 10 < 4) begin bcast_valid = 1; bcast_tag = 6'($urandom % 8); end
      fu_busy = {($urandom % 4 == 0), ($urandom % 4 == 0), ($urandom % 4 == 0)};
      if ($urandom % 50 == 0 && cyc > 10) begin
        flush_valid = 1; flush_stamp = cyc - ($urandom % 8);
      end
      step();
    end
    idle_inputs();
    for (int n = 0; n < 8; n++) begin bcast_valid = 1; bcast_tag = 6'(n); step(); end
    idle_inputs(); for (int n = 0; n < 12; n++) step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule